// File: doc/BRIEF.md
# Debug Event Combiner

This block takes a vector of single-bit debug event sources and reduces it to three registered requests: a debug-exception request, a trace-on request and a trace-off request. Each request has its own mask, where a set bit lets the matching source take part, and its own mode bit. The mode bit picks one of two rules. In OR mode any single enabled source is enough. In AND mode every enabled source must be high in the same cycle.

Software sets the masks and mode bits through a small synchronous write port. A combinational read port returns the same values. A source may be enabled for trace-on or for trace-off, but not for both. A write that would enable a source in both masks leaves that bit clear in the mask being written and raises a sticky conflict flag. The default source order, from bit 0 upward, is eight address-compare channels (0–7), one data-compare channel (8), a counter event (9), five external inputs (10–14) and a debug-instruction event (15). The logic treats all bits alike.

Top module: `dbg_evt_combiner`

## Requirements
- R1: After reset, all three masks and the mode register read zero, and `exc_req_o`, `trc_on_o`, `trc_off_o` and `clash_o` are low.
- R2: Writes with `wr_sel_i` 0, 1, 2 and 3 load the exception mask, the trace-on mask, the trace-off mask and the mode register. `rd_sel_i` uses the same codes. In the mode register, bit 0 selects AND mode for the exception request, bit 1 for trace-on and bit 2 for trace-off (1 = AND, 0 = OR). The other mode bits read zero.
- R3: In OR mode, an output condition is true when at least one enabled source is high. Sources that are not enabled have no effect.
- R4: In AND mode, an output condition is true only when every enabled source is high in the same cycle. Sources that are not enabled have no effect.
- R5: When a mask is all zero, its output never asserts, in either mode.
- R6: `exc_req_o` is a one-cycle pulse. It goes high in the cycle after the exception condition becomes true and is not repeated while the condition stays true.
- R7: `trc_on_o` and `trc_off_o` are levels. Each follows its own condition with one cycle of delay.
- R8: When the trace-on and trace-off conditions are true in the same cycle, only `trc_off_o` asserts.
- R9: A write to either trace mask keeps clear every bit that is already set in the other trace mask and stores all other bits as written. Any such dropped bit sets `clash_o`, which stays high until reset.
- R10: Each output uses only its own mode bit. One output can be in AND mode while another is in OR mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | SRC_W | Debug event sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selected for the write |
| wr_data_i | input | SRC_W | Write data |
| rd_sel_i | input | 2 | Register selected for the read |
| rd_data_o | output | SRC_W | Read data (combinational) |
| exc_req_o | output | 1 | Debug-exception request pulse |
| trc_on_o | output | 1 | Trace-on request |
| trc_off_o | output | 1 | Trace-off request |
| clash_o | output | 1 | Sticky trace-mask conflict flag |

## Verification
Two functions can meet in one cycle. The trace-on and trace-off conditions can both be true, and a trace-mask write can overlap a bit already set in the other trace mask. The bench sets up non-overlapping on and off masks and drives a source pattern that satisfies both in the same cycle. It expects only the off request and then checks that the on request returns once the off source drops. For the write clash, the bench writes overlapping patterns to each trace mask in turn. It reads back the stored mask, expecting only the overlapping bit to be dropped, and checks that the flag rises and stays set.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int unsigned SRC_W = 16;

  typedef enum logic [1:0] {
    SEL_EXC  = 2'd0,
    SEL_TON  = 2'd1,
    SEL_TOFF = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  localparam int unsigned MODE_EXC  = 0;
  localparam int unsigned MODE_TON  = 1;
  localparam int unsigned MODE_TOFF = 2;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned N_OUT     = 3;
endpackage

// File: rtl/dbg_evt_regs.sv
module dbg_evt_regs
  import dbg_evt_pkg::*;
#(
  parameter int unsigned W = SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [W-1:0]      rd_data_o,
  output logic [W-1:0]      exc_mask_o,
  output logic [W-1:0]      ton_mask_o,
  output logic [W-1:0]      toff_mask_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              clash_o
);
  localparam int unsigned PAD_W = W - MODE_W;

  logic [W-1:0]      exc_q, ton_q, toff_q;
  logic [MODE_W-1:0] mode_q;
  logic              clash_q;

  // Bits that a trace-mask write would have to drop
  logic [W-1:0] ton_drop, toff_drop;
  logic         wr_ton, wr_toff, clash_evt;

  assign wr_ton    = wr_en_i && (wr_sel_i == SEL_TON);
  assign wr_toff   = wr_en_i && (wr_sel_i == SEL_TOFF);
  assign ton_drop  = wr_data_i & toff_q;
  assign toff_drop = wr_data_i & ton_q;
  assign clash_evt = (wr_ton && (|ton_drop)) || (wr_toff && (|toff_drop));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q   <= '0;
      ton_q   <= '0;
      toff_q  <= '0;
      mode_q  <= '0;
      clash_q <= 1'b0;
    end else begin
      if (wr_en_i && (wr_sel_i == SEL_EXC))  exc_q  <= wr_data_i;
      if (wr_ton)                             ton_q  <= wr_data_i & ~toff_q;
      if (wr_toff)                            toff_q <= wr_data_i & ~ton_q;
      if (wr_en_i && (wr_sel_i == SEL_MODE)) mode_q <= wr_data_i[MODE_W-1:0];
      if (clash_evt)                          clash_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_EXC:  rd_data_o = exc_q;
      SEL_TON:  rd_data_o = ton_q;
      SEL_TOFF: rd_data_o = toff_q;
      default:  rd_data_o = {{PAD_W{1'b0}}, mode_q};
    endcase
  end

  assign exc_mask_o  = exc_q;
  assign ton_mask_o  = ton_q;
  assign toff_mask_o = toff_q;
  assign mode_o      = mode_q;
  assign clash_o     = clash_q;

  AST_MASKS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ton_q & toff_q) == '0); // R9
  AST_CLASH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_q |=> clash_q); // R9
endmodule

// File: rtl/dbg_evt_reduce.sv
module dbg_evt_reduce #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] src_i,
  input  logic         and_mode_i,
  output logic         hit_o
);
  // Masked reduction; an empty mask never qualifies
  function automatic logic combine(input logic [W-1:0] m,
                                   input logic [W-1:0] s,
                                   input logic         all_req);
    logic any_on, all_on;
    any_on = |(s & m);
    all_on = &(s | ~m);
    if (m == '0) return 1'b0;
    return all_req ? all_on : any_on;
  endfunction

  assign hit_o = combine(mask_i, src_i, and_mode_i);

  always_comb begin
    if (mask_i == '0) AST_EMPTY_NO_HIT: assert (!hit_o); // R5
  end
endmodule

// File: rtl/dbg_evt_combiner.sv
module dbg_evt_combiner
  import dbg_evt_pkg::*;
#(
  parameter int unsigned SRC_W_P = SRC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W_P-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [SRC_W_P-1:0] wr_data_i,
  input  logic [1:0]         rd_sel_i,
  output logic [SRC_W_P-1:0] rd_data_o,
  output logic               exc_req_o,
  output logic               trc_on_o,
  output logic               trc_off_o,
  output logic               clash_o
);
  logic [SRC_W_P-1:0] exc_mask, ton_mask, toff_mask;
  logic [MODE_W-1:0]  mode;

  dbg_evt_regs #(.W(SRC_W_P)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .exc_mask_o  (exc_mask),
    .ton_mask_o  (ton_mask),
    .toff_mask_o (toff_mask),
    .mode_o      (mode),
    .clash_o     (clash_o)
  );

  // One reducer per output, indexed like the mode bits
  logic [SRC_W_P-1:0] mask_arr [N_OUT];
  logic [N_OUT-1:0]   hit;

  assign mask_arr[MODE_EXC]  = exc_mask;
  assign mask_arr[MODE_TON]  = ton_mask;
  assign mask_arr[MODE_TOFF] = toff_mask;

  for (genvar k = 0; k < N_OUT; k++) begin : g_red
    dbg_evt_reduce #(.W(SRC_W_P)) u_red (
      .mask_i     (mask_arr[k]),
      .src_i      (src_i),
      .and_mode_i (mode[k]),
      .hit_o      (hit[k])
    );
  end

  // Named events for the assertions
  logic exc_hit, ton_hit, toff_hit, exc_rise, ton_pass;
  logic exc_hit_q;

  assign exc_hit  = hit[MODE_EXC];
  assign ton_hit  = hit[MODE_TON];
  assign toff_hit = hit[MODE_TOFF];
  assign exc_rise = exc_hit && !exc_hit_q;
  assign ton_pass = ton_hit && !toff_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_hit_q <= 1'b0;
      exc_req_o <= 1'b0;
      trc_on_o  <= 1'b0;
      trc_off_o <= 1'b0;
    end else begin
      exc_hit_q <= exc_hit;
      exc_req_o <= exc_rise;
      trc_on_o  <= ton_pass;
      trc_off_o <= toff_hit;
    end
  end

  AST_EXC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |=> !exc_req_o); // R6
  AST_TRACE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trc_on_o && trc_off_o)); // R8
  AST_EXC_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(exc_mask) == '0) |-> !exc_req_o); // R5
  AST_TOFF_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toff_hit |=> trc_off_o); // R7
endmodule

// File: tb/dbg_evt_combiner_tb.sv
module dbg_evt_combiner_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] src = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_sel = '0;
  logic [W-1:0] rd_data;
  logic         exc_req, trc_on, trc_off, clash;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dbg_evt_combiner dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .exc_req_o(exc_req), .trc_on_o(trc_on), .trc_off_o(trc_off),
    .clash_o(clash)
  );

  task automatic chk(input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sel,
                        input logic [W-1:0] exp);
    rd_sel = sel;
    #1;
    chk(tag, rd_data, exp);
  endtask

  // Apply a source pattern; outputs are valid at the following negedge
  task automatic drive(input logic [W-1:0] s);
    src = s;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 4; s++) rd_chk("R1 reg zero", 2'(s), '0);
    chk("R1 exc",   16'(exc_req), 0);
    chk("R1 ton",   16'(trc_on), 0);
    chk("R1 toff",  16'(trc_off), 0);
    chk("R1 clash", 16'(clash), 0);
  endtask

  task automatic t_rw;
    wr(2'd0, 16'hA5C3);
    rd_chk("R2 exc mask", 2'd0, 16'hA5C3);
    wr(2'd3, 16'hFFFF);
    rd_chk("R2 mode pad", 2'd3, 16'h0007);
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_zero;
    wr(2'd3, 16'h0007);
    drive(16'hFFFF);
    chk("R5 exc empty", 16'(exc_req), 0);
    chk("R5 ton empty", 16'(trc_on), 0);
    chk("R5 toff empty", 16'(trc_off), 0);
    wr(2'd3, 16'h0000);
    drive(16'hFFFF);
    chk("R5 exc empty OR", 16'(exc_req), 0);
    drive('0);
  endtask

  task automatic t_or;
    wr(2'd0, 16'h0101);
    drive(16'h0100);
    chk("R3 one enabled", 16'(exc_req), 1);
    drive('0);
    drive(16'h0002);
    chk("R3 disabled src", 16'(exc_req), 0);
    drive('0);
  endtask

  task automatic t_and;
    wr(2'd3, 16'h0001);
    drive(16'h0001);
    chk("R4 partial", 16'(exc_req), 0);
    drive(16'h0101);
    chk("R4 all", 16'(exc_req), 1);
    drive('0);
    drive(16'hFFFF);
    chk("R4 extra ignored", 16'(exc_req), 1);
    drive('0);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_pulse;
    wr(2'd0, 16'h8000);
    drive(16'h8000);
    chk("R6 first", 16'(exc_req), 1);
    drive(16'h8000);
    chk("R6 held", 16'(exc_req), 0);
    drive(16'h8000);
    chk("R6 held2", 16'(exc_req), 0);
    drive('0);
  endtask

  task automatic t_level;
    wr(2'd1, 16'h0600);
    drive(16'h0200);
    chk("R7 ton set", 16'(trc_on), 1);
    drive(16'h0200);
    chk("R7 ton level", 16'(trc_on), 1);
    drive('0);
    chk("R7 ton clear", 16'(trc_on), 0);
  endtask

  task automatic t_indep;
    wr(2'd0, 16'h0600);
    wr(2'd3, 16'h0002);
    drive(16'h0200);
    chk("R10 exc OR", 16'(exc_req), 1);
    chk("R10 ton AND", 16'(trc_on), 0);
    drive('0);
    drive(16'h0600);
    chk("R10 ton AND all", 16'(trc_on), 1);
    chk("R10 exc OR again", 16'(exc_req), 1);
    drive('0);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_off_wins;
    wr(2'd2, 16'h0001);
    drive(16'h0201);
    chk("R8 ton blocked", 16'(trc_on), 0);
    chk("R8 toff", 16'(trc_off), 1);
    drive(16'h0200);
    chk("R8 ton back", 16'(trc_on), 1);
    chk("R7 toff clear", 16'(trc_off), 0);
    drive('0);
  endtask

  task automatic t_clash;
    chk("R9 no clash yet", 16'(clash), 0);
    wr(2'd2, 16'h0401);
    rd_chk("R9 toff dropped", 2'd2, 16'h0001);
    chk("R9 clash set", 16'(clash), 1);
    wr(2'd1, 16'h0003);
    rd_chk("R9 ton dropped", 2'd1, 16'h0002);
    wr(2'd0, 16'h0000);
    chk("R9 clash sticky", 16'(clash), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_zero();
    t_or();
    t_and();
    t_pulse();
    t_level();
    t_indep();
    t_off_wins();
    t_clash();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule